// File: doc/BRIEF.md
# Display Integrity Status and Interrupt Controller

This block sits next to a display region checker and holds all of its software-visible result state. The checker sends two kinds of pulses: one when a frame's results are ready, and one per region when that region's signature did not match. The block turns these pulses into sticky flags that software clears by writing 1. It derives an error summary from the region flags and raises a level interrupt under a pair of mask bits. The mask bits can be frozen until reset. The block also holds each region's window, enable and reference signature, and a per-region lock protects the window and enable from being changed.

A second, slow-moving indication leaves the chip on a single pin as a square wave. Its rate tells an outside observer whether the display path is healthy or in error. The pin rests at 0 whenever checking or the pin itself is disabled. The register port is a single-cycle write strobe plus a read strobe, with the read data registered one cycle later.

Top module: `integrity_status_ctrl`

## Requirements
- R1: After reset, the status register reads 0, the interrupt control register reads 3 (both masks set, freeze clear), every region register reads 0, and `irq` and `ext_mismatch` are 0.
- R2: While checking is enabled (control register, address 0, bit 0), a pulse on `roi_mismatch[r]` sets region flag r, which is status register (address 1) bit 2+r. The flag stays set until a status write has 1 in that bit. Writing 0 there has no effect, and pulses while checking is disabled are dropped.
- R3: While checking is enabled, a `frame_done` pulse sets the results-ready flag (status bit 0). A status write with bit 0 high clears it.
- R4: Status bit 1 reads as the OR of all region flags. Writes to bit 1 are ignored, so it falls only once every set region flag has been cleared.
- R5: `irq` is registered and active high. One cycle after the flags and masks settle, it equals (ready AND NOT mask0) OR (error AND NOT mask1), where mask0 and mask1 are bits 0 and 1 of the interrupt control register (address 2). A mask bit of 1 disables its source, and both mask bits reset to 1.
- R6: Writing 1 to interrupt control bit 2 sets a freeze bit. From then until reset, the mask bits and the freeze bit ignore every write. A write that sets freeze still applies the mask bits it carries.
- R7: Region r has a window register at address 4+2r and a reference register at address 5+2r. The window register holds the packed window in bits [WIN_W-1:0], the lock in bit 30 and the enable in bit 31. Once the lock is set, writes to the window register are ignored until reset. The reference register stays writable, and all three values drive the region outputs.
- R8: `ext_mismatch` stays at 0 unless both checking (control bit 0) and the external indication (control bit 1) are enabled.
- R9: When enabled with the error bit set, `ext_mismatch` toggles every 8 clock cycles, which is a period of the clock divided by 16.
- R10: When enabled with the error bit clear, `ext_mismatch` toggles every 2 clock cycles, which is a period of the clock divided by 4.
- R11: When the error bit changes while the output is active, the divider restarts. After a mismatch pulse sampled at edge P, the first toggle at the slow rate lands exactly at edge P+9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checker clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_re` |
| frame_done | input | 1 | One-cycle results-ready pulse from the checker |
| roi_mismatch | input | N_ROI | One-cycle per-region mismatch pulses |
| check_en | output | 1 | Global integrity-check enable |
| roi_enable | output | N_ROI | Per-region enable |
| roi_window | output | N_ROI*WIN_W | Packed per-region windows, region 0 lowest |
| roi_ref | output | N_ROI*REF_W | Per-region reference signatures, region 0 lowest |
| irq | output | 1 | Level interrupt, active high |
| ext_mismatch | output | 1 | External two-rate heartbeat |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any other activity. They also treat `roi_mismatch` and `frame_done` as arbitrary per-cycle inputs, so two pulses may arrive on back-to-back cycles without breaking them. The stickiness and lock properties rely only on the register port protocol, one write per strobed cycle. The stimulus never drives a read and a write in the same cycle and never leaves a pulse high for more than one cycle. It sweeps every mask value against every combination of ready and error, and every region index for setting and clearing flags.

// File: rtl/integ_pkg.sv
package integ_pkg;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_STATUS   = 1;
  localparam int ADDR_IRQCTL   = 2;
  localparam int ADDR_ROI_BASE = 4;

  localparam int CTRL_CHECK    = 0;
  localparam int CTRL_EXT      = 1;

  localparam int STAT_READY    = 0;
  localparam int STAT_ERR      = 1;
  localparam int STAT_ROI0     = 2;

  localparam int IRQ_MASK_RDY  = 0;
  localparam int IRQ_MASK_ERR  = 1;
  localparam int IRQ_FREEZE    = 2;

  typedef enum logic {HB_FAST = 1'b0, HB_SLOW = 1'b1} hb_rate_e;
endpackage

// File: rtl/isc_flags.sv
module isc_flags #(
  parameter int N_ROI = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             check_en,
  input  logic             frame_done,
  input  logic [N_ROI-1:0] roi_mismatch,
  input  logic             clr_ready,
  input  logic [N_ROI-1:0] clr_roi,
  output logic             ready_q,
  output logic [N_ROI-1:0] roi_flag_q,
  output logic             err
);
  // set has priority over a clear in the same cycle so no event is lost
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      roi_flag_q <= '0;
    end else begin
      ready_q    <= (ready_q & ~clr_ready) | (check_en & frame_done);
      roi_flag_q <= (roi_flag_q & ~clr_roi) | ({N_ROI{check_en}} & roi_mismatch);
    end
  end

  assign err = |roi_flag_q;
endmodule

// File: rtl/isc_irq.sv
module isc_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       we_ctl,
  input  logic [2:0] wdata,
  input  logic       ready,
  input  logic       err,
  output logic       mask_ready,
  output logic       mask_err,
  output logic       freeze,
  output logic       irq
);
  import integ_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_ready <= 1'b1;
      mask_err   <= 1'b1;
      freeze     <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (we_ctl && !freeze) begin
        mask_ready <= wdata[IRQ_MASK_RDY];
        mask_err   <= wdata[IRQ_MASK_ERR];
        freeze     <= wdata[IRQ_FREEZE];
      end
      irq <= (ready & ~mask_ready) | (err & ~mask_err);
    end
  end
endmodule

// File: rtl/isc_roi_cfg.sv
module isc_roi_cfg #(
  parameter int N_ROI  = 4,
  parameter int WIN_W  = 24,
  parameter int REF_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_ROI-1:0]       we_win,
  input  logic [N_ROI-1:0]       we_ref,
  input  logic [DATA_W-1:0]      wdata,
  output logic [N_ROI*WIN_W-1:0] win,
  output logic [N_ROI-1:0]       en,
  output logic [N_ROI-1:0]       lock,
  output logic [N_ROI*REF_W-1:0] refsig
);
  localparam int BIT_EN   = DATA_W - 1;
  localparam int BIT_LOCK = DATA_W - 2;

  for (genvar r = 0; r < N_ROI; r++) begin : g_roi
    always_ff @(posedge clk) begin
      if (rst) begin
        win[r*WIN_W +: WIN_W] <= '0;
        en[r]                 <= 1'b0;
        lock[r]               <= 1'b0;
      end else if (we_win[r] && !lock[r]) begin
        win[r*WIN_W +: WIN_W] <= wdata[WIN_W-1:0];
        en[r]                 <= wdata[BIT_EN];
        lock[r]               <= wdata[BIT_LOCK];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) refsig[r*REF_W +: REF_W] <= '0;
      else if (we_ref[r]) refsig[r*REF_W +: REF_W] <= wdata[REF_W-1:0];
    end
  end
endmodule

// File: rtl/isc_heartbeat.sv
module isc_heartbeat #(
  parameter int DIV_ERR = 16,
  parameter int DIV_OK  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic err,
  output logic hb
);
  import integ_pkg::*;

  localparam int HALF_SLOW = DIV_ERR / 2;
  localparam int HALF_FAST = DIV_OK / 2;
  localparam int CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(HALF_SLOW - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(HALF_FAST - 1);

  hb_rate_e          rate_q;
  hb_rate_e          rate_want;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_last;

  assign rate_want = err ? HB_SLOW : HB_FAST;
  assign cnt_last  = (rate_q == HB_SLOW) ? LAST_SLOW : LAST_FAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb     <= 1'b0;
      cnt_q  <= '0;
      rate_q <= HB_FAST;
    end else if (!active) begin
      hb     <= 1'b0;
      cnt_q  <= '0;
      rate_q <= rate_want;
    end else if (rate_want != rate_q) begin
      rate_q <= rate_want;
      cnt_q  <= '0;
    end else if (cnt_q == cnt_last) begin
      hb    <= ~hb;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/integrity_status_ctrl.sv
module integrity_status_ctrl #(
  parameter int N_ROI   = 4,
  parameter int COORD_W = 6,
  parameter int DATA_W  = 32,
  parameter int REF_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int DIV_ERR = 16,
  parameter int DIV_OK  = 4,
  localparam int WIN_W  = 4 * COORD_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic                   reg_re,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic                   frame_done,
  input  logic [N_ROI-1:0]       roi_mismatch,
  output logic                   check_en,
  output logic [N_ROI-1:0]       roi_enable,
  output logic [N_ROI*WIN_W-1:0] roi_window,
  output logic [N_ROI*REF_W-1:0] roi_ref,
  output logic                   irq,
  output logic                   ext_mismatch
);
  import integ_pkg::*;

  localparam int BIT_EN   = DATA_W - 1;
  localparam int BIT_LOCK = DATA_W - 2;

  logic             ext_en;
  logic             hit_ctrl, hit_stat, hit_irq;
  logic [N_ROI-1:0] we_win, we_ref;
  logic             ready_q, err;
  logic [N_ROI-1:0] roi_flag;
  logic [N_ROI-1:0] roi_lock;
  logic             mask_ready, mask_err, freeze;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign hit_stat = reg_we && (reg_addr == ADDR_W'(ADDR_STATUS));
  assign hit_irq  = reg_we && (reg_addr == ADDR_W'(ADDR_IRQCTL));

  for (genvar r = 0; r < N_ROI; r++) begin : g_dec
    localparam int A_WIN = ADDR_ROI_BASE + 2 * r;
    assign we_win[r] = reg_we && (reg_addr == ADDR_W'(A_WIN));
    assign we_ref[r] = reg_we && (reg_addr == ADDR_W'(A_WIN + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      check_en <= 1'b0;
      ext_en   <= 1'b0;
    end else if (hit_ctrl) begin
      check_en <= reg_wdata[CTRL_CHECK];
      ext_en   <= reg_wdata[CTRL_EXT];
    end
  end

  isc_flags #(.N_ROI(N_ROI)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .check_en     (check_en),
    .frame_done   (frame_done),
    .roi_mismatch (roi_mismatch),
    .clr_ready    (hit_stat & reg_wdata[STAT_READY]),
    .clr_roi      ({N_ROI{hit_stat}} & reg_wdata[STAT_ROI0 +: N_ROI]),
    .ready_q      (ready_q),
    .roi_flag_q   (roi_flag),
    .err          (err)
  );

  isc_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .we_ctl     (hit_irq),
    .wdata      (reg_wdata[2:0]),
    .ready      (ready_q),
    .err        (err),
    .mask_ready (mask_ready),
    .mask_err   (mask_err),
    .freeze     (freeze),
    .irq        (irq)
  );

  isc_roi_cfg #(
    .N_ROI(N_ROI), .WIN_W(WIN_W), .REF_W(REF_W), .DATA_W(DATA_W)
  ) u_roi (
    .clk    (clk),
    .rst    (rst),
    .we_win (we_win),
    .we_ref (we_ref),
    .wdata  (reg_wdata),
    .win    (roi_window),
    .en     (roi_enable),
    .lock   (roi_lock),
    .refsig (roi_ref)
  );

  isc_heartbeat #(.DIV_ERR(DIV_ERR), .DIV_OK(DIV_OK)) u_hb (
    .clk    (clk),
    .rst    (rst),
    .active (check_en & ext_en),
    .err    (err),
    .hb     (ext_mismatch)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_mux[CTRL_CHECK] = check_en;
      rd_mux[CTRL_EXT]   = ext_en;
    end else if (reg_addr == ADDR_W'(ADDR_STATUS)) begin
      rd_mux[STAT_READY]          = ready_q;
      rd_mux[STAT_ERR]            = err;
      rd_mux[STAT_ROI0 +: N_ROI]  = roi_flag;
    end else if (reg_addr == ADDR_W'(ADDR_IRQCTL)) begin
      rd_mux[IRQ_MASK_RDY] = mask_ready;
      rd_mux[IRQ_MASK_ERR] = mask_err;
      rd_mux[IRQ_FREEZE]   = freeze;
    end
    for (int r = 0; r < N_ROI; r++) begin
      if (reg_addr == ADDR_W'(ADDR_ROI_BASE + 2 * r)) begin
        rd_mux[WIN_W-1:0] = roi_window[r*WIN_W +: WIN_W];
        rd_mux[BIT_LOCK]  = roi_lock[r];
        rd_mux[BIT_EN]    = roi_enable[r];
      end
      if (reg_addr == ADDR_W'(ADDR_ROI_BASE + 2 * r + 1)) begin
        rd_mux[REF_W-1:0] = roi_ref[r*REF_W +: REF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/integrity_status_sva.sv
module integrity_status_sva #(
  parameter int N_ROI  = 4,
  parameter int WIN_W  = 24,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_we,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [N_ROI-1:0]       stat_wdata,
  input logic                   check_en,
  input logic                   ext_en,
  input logic                   ext_mismatch,
  input logic                   irq,
  input logic                   mask_ready,
  input logic                   mask_err,
  input logic                   freeze,
  input logic [N_ROI-1:0]       roi_flag,
  input logic [N_ROI-1:0]       roi_lock,
  input logic [N_ROI-1:0]       roi_enable,
  input logic [N_ROI*WIN_W-1:0] roi_window
);
  logic stat_hit;
  assign stat_hit = reg_we && (reg_addr == ADDR_W'(1));

  assert_ext_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !(check_en && ext_en) |=> !ext_mismatch);

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (mask_ready && mask_err) |=> !irq);

  assert_masks_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (freeze && $stable(mask_ready) && $stable(mask_err)));

  for (genvar r = 0; r < N_ROI; r++) begin : g_chk
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      (roi_flag[r] && !(stat_hit && stat_wdata[r])) |=> roi_flag[r]);

    assert_region_locked_R7: assert property (@(posedge clk) disable iff (rst)
      roi_lock[r] |=> (roi_lock[r] && $stable(roi_enable[r]) &&
                       $stable(roi_window[r*WIN_W +: WIN_W])));
  end
endmodule

bind integrity_status_ctrl integrity_status_sva #(
  .N_ROI(N_ROI), .WIN_W(WIN_W), .ADDR_W(ADDR_W)
) u_sva (
  .clk          (clk),
  .rst          (rst),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .stat_wdata   (reg_wdata[2 +: N_ROI]),
  .check_en     (check_en),
  .ext_en       (ext_en),
  .ext_mismatch (ext_mismatch),
  .irq          (irq),
  .mask_ready   (mask_ready),
  .mask_err     (mask_err),
  .freeze       (freeze),
  .roi_flag     (roi_flag),
  .roi_lock     (roi_lock),
  .roi_enable   (roi_enable),
  .roi_window   (roi_window)
);

// File: tb/test_integrity_status_ctrl.sv
module test_integrity_status_ctrl;
  localparam int N     = 4;
  localparam int CW    = 6;
  localparam int DW    = 32;
  localparam int RW    = 32;
  localparam int AW    = 4;
  localparam int WW    = 4 * CW;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_we, reg_re;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          frame_done;
  logic [N-1:0]  roi_mismatch;
  logic          check_en;
  logic [N-1:0]  roi_enable;
  logic [N*WW-1:0] roi_window;
  logic [N*RW-1:0] roi_ref;
  logic          irq, ext_mismatch;

  integer total = 0, bad = 0;
  integer cyc = 0, last_chg = 0, chg_count = 0;
  logic   prev_ext = 1'b0;

  always #5 clk = ~clk;

  integrity_status_ctrl #(.N_ROI(N), .COORD_W(CW), .DATA_W(DW), .REF_W(RW), .ADDR_W(AW))
  i_integrity_status_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_done(frame_done),
    .roi_mismatch(roi_mismatch), .check_en(check_en), .roi_enable(roi_enable),
    .roi_window(roi_window), .roi_ref(roi_ref), .irq(irq), .ext_mismatch(ext_mismatch)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (ext_mismatch !== prev_ext) begin
      prev_ext  = ext_mismatch;
      last_chg  = cyc;
      chg_count = chg_count + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); reg_re = 1'b1; reg_addr = AW'(a);
    @(posedge clk);
    @(negedge clk); reg_re = 1'b0; v = reg_rdata;
  endtask

  task automatic pulse_roi(input int r);
    @(negedge clk); roi_mismatch[r] = 1'b1;
    @(posedge clk);
    @(negedge clk); roi_mismatch = '0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_done = 1'b1;
    @(posedge clk);
    @(negedge clk); frame_done = 1'b0;
  endtask

  // skip `skip` changes, then return the spacing of the next two changes
  task automatic gap(input int skip, output int g);
    int n0, t1;
    n0 = chg_count;
    while (chg_count < n0 + skip + 1) @(negedge clk);
    t1 = last_chg;
    while (chg_count < n0 + skip + 2) @(negedge clk);
    g = last_chg - t1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int g, k, zeros;
    rst = 1'b1; reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
    frame_done = 0; roi_mismatch = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(1, v); chk("R1 status", v, 0);
    rd(2, v); chk("R1 irqctl", v, 3);
    for (int a = 4; a < 4 + 2 * N; a++) begin rd(a, v); chk("R1 region reg", v, 0); end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ext", {31'b0, ext_mismatch}, 0);

    // R2 pulse dropped while checking disabled
    pulse_roi(0); pulse_frame();
    rd(1, v); chk("R2 disabled drop", v, 0);

    wr(0, 32'h1);
    // R3 ready flag
    pulse_frame();
    rd(1, v); chk("R3 ready set", v, 1);
    wr(1, 32'h1);
    rd(1, v); chk("R3 ready cleared", v, 0);

    // R2 per-region sweep
    for (int r = 0; r < N; r++) begin
      pulse_roi(r);
      rd(1, v); chk("R2 set", v, (32'h1 << (2 + r)) | 32'h2);
      wr(1, ~(32'h1 << (2 + r)) & 32'h1);
      rd(1, v); chk("R2 write zero kept", v, (32'h1 << (2 + r)) | 32'h2);
      wr(1, 32'h1 << (2 + r));
      rd(1, v); chk("R2 cleared", v, 0);
    end

    // R4 error summary
    pulse_roi(0); pulse_roi(2);
    rd(1, v); chk("R4 err set", v, 32'h16);
    wr(1, 32'h2);
    rd(1, v); chk("R4 err write ignored", v, 32'h16);
    wr(1, 32'h4);
    rd(1, v); chk("R4 err held by other flag", v, 32'h12);
    wr(1, 32'h10);
    rd(1, v); chk("R4 err cleared", v, 0);

    // R5 mask x state sweep
    for (int st = 0; st < 4; st++) begin
      for (int m = 0; m < 4; m++) begin
        wr(1, 32'hFFFF_FFFF);
        if (st[0]) pulse_frame();
        if (st[1]) pulse_roi(1);
        wr(2, 32'(m));
        repeat (2) @(negedge clk);
        chk("R5 irq", {31'b0, irq}, ((st[0] & ~m[0]) | (st[1] & ~m[1])) ? 1 : 0);
      end
    end
    wr(1, 32'hFFFF_FFFF);

    // R6 freeze
    wr(2, 32'h5);
    rd(2, v); chk("R6 freeze applied", v, 5);
    wr(2, 32'h0);
    rd(2, v); chk("R6 clear ignored", v, 5);
    wr(2, 32'h3);
    rd(2, v); chk("R6 mask write ignored", v, 5);

    // R7 region lock
    wr(6, 32'h8000_0000 | 32'h00AB_CDEF);
    rd(6, v); chk("R7 window write", v, 32'h80AB_CDEF);
    wr(6, 32'hC012_3456);
    rd(6, v); chk("R7 lock write", v, 32'hC012_3456);
    wr(6, 32'h0065_4321);
    rd(6, v); chk("R7 locked ignored", v, 32'hC012_3456);
    chk("R7 window out", {8'b0, roi_window[WW +: WW]}, 32'h0012_3456);
    chk("R7 enable out", {28'b0, roi_enable}, 32'h2);
    wr(7, 32'hDEAD_BEEF);
    rd(7, v); chk("R7 ref writable", v, 32'hDEAD_BEEF);
    chk("R7 ref out", roi_ref[RW +: RW], 32'hDEAD_BEEF);
    wr(4, 32'h0000_0011);
    rd(4, v); chk("R7 unlocked region", v, 32'h11);

    // R8 idle when either enable is off
    zeros = 0;
    wr(0, 32'h1);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ext_mismatch) zeros++; end
    wr(0, 32'h2);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ext_mismatch) zeros++; end
    chk("R8 idle high count", 32'(zeros), 0);

    // R10 fast rate
    wr(0, 32'h3);
    gap(1, g); chk("R10 fast half period", 32'(g), 2);
    gap(0, g); chk("R10 fast half period again", 32'(g), 2);

    // R11 restart on rate change, R9 slow rate
    @(negedge clk); k = cyc; roi_mismatch[3] = 1'b1;
    @(posedge clk);
    @(negedge clk); roi_mismatch = '0;
    while (last_chg <= k + 1) @(negedge clk);
    chk("R11 first slow toggle", 32'(last_chg - k), 10);
    gap(0, g); chk("R9 slow half period", 32'(g), 8);
    gap(0, g); chk("R9 slow half period again", 32'(g), 8);

    // back to fast after clearing
    wr(1, 32'h20);
    gap(2, g); chk("R10 fast after clear", 32'(g), 2);

    // R8 disable returns to idle
    wr(0, 32'h1);
    repeat (2) @(negedge clk);
    chk("R8 idle after disable", {31'b0, ext_mismatch}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule